// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a DMA address issued by a device function into a host physical address. It walks a three-level table held in memory: a region table, then a segment table, then a page table. The walk starts from a per-function table origin. The DMA address supplies one index for each level, and the walker fetches 64-bit entries through a single read port, keeping at most one read in flight. A successful walk returns a page-aligned host address, a 4 KB offset mask and a permission.

Three checks can end a request early, before any table read. A single fixed message-signalled-interrupt address is passed through untranslated and marked for redirection to the interrupt notification target. A function with no table origin configured faults. An address outside the function's permitted DMA window also faults.

Every fault is reported together with the faulting address and a fault code. A fault also sets two sticky flags for the function: one marking it as in error and one blocking its stores. The walker handles one request at a time and accepts a new one only when idle.

Top module: `dma_xlat_walker`

## Requirements
- R1: A request whose address equals MSI_ADDR (default 64'hFE00_0000) completes one cycle after acceptance without any table read. It returns rspAddr equal to the request address, rspPerm 2'b11 (read-write), rspMask 64'hFFF, rspMsi 1 and rspFault 0. This check takes priority over R2 and R3.
- R2: A request with tblOrigin equal to zero completes one cycle after acceptance with rspFault 1, faultCode 2'd1 and faultQual 0, and no table read takes place.
- R3: An address below winBase or above winLimit faults one cycle after acceptance with faultCode 2'd2 and no table read. An address equal to winBase or to winLimit is accepted for the walk.
- R4: The region index is address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12]. Each level reads the entry at its table base plus index×8. The first table base is tblOrigin with bits [3:0] cleared.
- R5: A region entry is followed only if its bits [3:2] equal 2'b11, and the segment table base is that entry with bits [13:0] cleared. A segment entry is followed only if its bits [3:2] equal 2'b10, and the page table base is that entry with bits [10:0] cleared. Any other type value ends the walk with faultCode 2'd3 and faultQual 1, and no further reads take place.
- R6: A page entry equal to zero faults with faultCode 2'd3 and faultQual 1.
- R7: For a nonzero page entry, the response has rspFault 0, rspMsi 0, rspAddr equal to the entry with bits [11:0] cleared, and rspMask 64'hFFF. rspPerm is 2'b00 when entry bit 10 is set and 2'b11 otherwise.
- R8: A faulting response carries faultAddr equal to the request address, rspAddr 0, rspPerm 2'b00 and rspMask all ones. errorState and storeBlocked are both set in the same cycle as that response and stay set until reset.
- R9: reqReady is high only while idle. A request held during a walk is ignored and produces no response and no read. At most one table read is outstanding at any time, and rspValid is a one-cycle pulse.
- R10: After reset, reqReady is 1 and rspValid, memRdValid, errorState and storeBlocked are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqAddr | input | 64 | Device DMA address |
| tblOrigin | input | 64 | Per-function table origin, zero when unconfigured |
| winBase | input | 64 | Lowest permitted DMA address |
| winLimit | input | 64 | Highest permitted DMA address |
| memRdValid | output | 1 | Table read request, one-cycle pulse |
| memRdAddr | output | 64 | Byte address of the table entry |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Table entry |
| rspValid | output | 1 | Result valid, one-cycle pulse |
| rspAddr | output | 64 | Translated host address |
| rspMask | output | 64 | Offset mask of the translation |
| rspPerm | output | 2 | Permission, 00 none, 11 read-write |
| rspMsi | output | 1 | Redirect to interrupt notification target |
| rspFault | output | 1 | Request faulted |
| faultCode | output | 2 | 1 no origin, 2 out of window, 3 walk error |
| faultQual | output | 1 | Qualifier bit of the error word |
| faultAddr | output | 64 | Faulting request address |
| errorState | output | 1 | Sticky function error flag |
| storeBlocked | output | 1 | Sticky store-blocked flag |

## Verification
Two behaviours can coincide in one cycle: the walker finishing a walk (its response cycle), and a second request already waiting at the input. The bench provokes this by holding a new request, aimed at the interrupt bypass address, asserted throughout a walk. It then releases the request in the response cycle. The response is judged against the model's result for the first address, and no extra response or table read may follow. The early decisions are also made to collide: the bypass address is sent with no origin configured, and only the bypass outcome may appear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_NOSPACE = 2'd1,
    FLT_RANGE   = 2'd2,
    FLT_WALK    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RTE,
    ST_STE,
    ST_PTE,
    ST_DONE
  } walk_e;

  typedef enum logic [1:0] {
    LVL_RGN = 2'd0,
    LVL_SEG = 2'd1,
    LVL_PG  = 2'd2
  } level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   advance;
    level_e level;
    logic   finMsi;
    logic   finFault;
    fault_e code;
    logic   qual;
    logic   finPage;
  } strobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic isMsi;
    logic noOrigin;
    logic outRange;
    logic entryTypeOk;
    logic entryZero;
  } status_t;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;

  localparam logic [1:0] RGN_TYPE_CODE = 2'b11;
  localparam logic [1:0] SEG_TYPE_CODE = 2'b10;
  localparam int TYPE_LSB       = 2;
  localparam int ORIGIN_FLAG_W  = 4;
  localparam int RGN_LOW_W      = 14;
  localparam int SEG_LOW_W      = 11;
  localparam int PTE_INVALID_BIT = 10;
  localparam int ENTRY_SHIFT    = 3;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  status_t  stat,
  output strobes_t strb,
  output logic     reqReady,
  output logic     rspValid,
  output logic     memRdValid
);

  walk_e stateQ, stateD;
  logic  pendQ;
  logic  rspTaken;

  assign rspTaken = pendQ && memRspValid;

  always_comb begin
    stateD     = stateQ;
    strb       = '0;
    strb.level = LVL_RGN;
    strb.code  = FLT_NONE;
    reqReady   = 1'b0;
    rspValid   = 1'b0;
    memRdValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capture = 1'b1;
          if (stat.isMsi) begin
            strb.finMsi = 1'b1;
            stateD      = ST_DONE;
          end else if (stat.noOrigin) begin
            strb.finFault = 1'b1;
            strb.code     = FLT_NOSPACE;
            stateD        = ST_DONE;
          end else if (stat.outRange) begin
            strb.finFault = 1'b1;
            strb.code     = FLT_RANGE;
            stateD        = ST_DONE;
          end else begin
            stateD = ST_RTE;
          end
        end
      end
      ST_RTE, ST_STE: begin
        strb.level = (stateQ == ST_RTE) ? LVL_RGN : LVL_SEG;
        memRdValid = !pendQ;
        if (rspTaken) begin
          if (stat.entryTypeOk) begin
            strb.advance = 1'b1;
            stateD       = (stateQ == ST_RTE) ? ST_STE : ST_PTE;
          end else begin
            strb.finFault = 1'b1;
            strb.code     = FLT_WALK;
            strb.qual     = 1'b1;
            stateD        = ST_DONE;
          end
        end
      end
      ST_PTE: begin
        strb.level = LVL_PG;
        memRdValid = !pendQ;
        if (rspTaken) begin
          if (stat.entryZero) begin
            strb.finFault = 1'b1;
            strb.code     = FLT_WALK;
            strb.qual     = 1'b1;
          end else begin
            strb.finPage = 1'b1;
          end
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (memRdValid) pendQ <= 1'b1;
      else if (rspTaken) pendQ <= 1'b0;
    end
  end

endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int RGN_W      = 11,
  parameter int SEG_W      = 11,
  parameter int PG_W       = 8,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] tblOrigin,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic [ADDR_W-1:0] memRspData,
  output status_t           stat,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] rspMask,
  output logic [1:0]        rspPerm,
  output logic              rspMsi,
  output logic              rspFault,
  output logic [1:0]        faultCode,
  output logic              faultQual,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              errorState,
  output logic              storeBlocked
);

  localparam int SEG_SHIFT = PAGE_SHIFT + PG_W;
  localparam int RGN_SHIFT = SEG_SHIFT + SEG_W;
  localparam logic [ADDR_W-1:0] ALL_ONES    = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] PAGE_MASK   = ~(ALL_ONES << PAGE_SHIFT);
  localparam logic [ADDR_W-1:0] ORIGIN_KEEP = ALL_ONES << ORIGIN_FLAG_W;
  localparam logic [ADDR_W-1:0] RGN_KEEP    = ALL_ONES << RGN_LOW_W;
  localparam logic [ADDR_W-1:0] SEG_KEEP    = ALL_ONES << SEG_LOW_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] lvlOff [3];
  logic [ADDR_W-1:0] curAddr;
  logic [1:0]        typeField;

  // per-level entry offset inside its table
  for (genvar g = 0; g < 3; g++) begin : gLvl
    localparam int LSB = (g == 0) ? RGN_SHIFT : (g == 1) ? SEG_SHIFT : PAGE_SHIFT;
    localparam int W   = (g == 0) ? RGN_W : (g == 1) ? SEG_W : PG_W;
    assign lvlOff[g] = ADDR_W'(addrQ[LSB +: W]) << ENTRY_SHIFT;
  end

  always_comb begin
    case (strb.level)
      LVL_RGN: memRdAddr = ptrQ + lvlOff[0];
      LVL_SEG: memRdAddr = ptrQ + lvlOff[1];
      default: memRdAddr = ptrQ + lvlOff[2];
    endcase
  end

  assign typeField = memRspData[TYPE_LSB +: 2];
  assign curAddr   = strb.capture ? reqAddr : addrQ;

  always_comb begin
    stat.isMsi    = (reqAddr == MSI_ADDR);
    stat.noOrigin = (tblOrigin == '0);
    stat.outRange = (reqAddr < winBase) || (reqAddr > winLimit);
    stat.entryZero = (memRspData == '0);
    case (strb.level)
      LVL_RGN: stat.entryTypeOk = (typeField == RGN_TYPE_CODE);
      LVL_SEG: stat.entryTypeOk = (typeField == SEG_TYPE_CODE);
      default: stat.entryTypeOk = 1'b1;
    endcase
  end

  // walk registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      ptrQ  <= '0;
    end else if (strb.capture) begin
      addrQ <= reqAddr;
      ptrQ  <= tblOrigin & ORIGIN_KEEP;
    end else if (strb.advance) begin
      ptrQ <= (strb.level == LVL_RGN) ? (memRspData & RGN_KEEP)
                                      : (memRspData & SEG_KEEP);
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAddr      <= '0;
      rspMask      <= '0;
      rspPerm      <= PERM_NONE;
      rspMsi       <= 1'b0;
      rspFault     <= 1'b0;
      faultCode    <= FLT_NONE;
      faultQual    <= 1'b0;
      faultAddr    <= '0;
      errorState   <= 1'b0;
      storeBlocked <= 1'b0;
    end else begin
      if (strb.finMsi) begin
        rspAddr   <= reqAddr;
        rspMask   <= PAGE_MASK;
        rspPerm   <= PERM_RW;
        rspMsi    <= 1'b1;
        rspFault  <= 1'b0;
        faultCode <= FLT_NONE;
        faultQual <= 1'b0;
      end else if (strb.finFault) begin
        rspAddr      <= '0;
        rspMask      <= ALL_ONES;
        rspPerm      <= PERM_NONE;
        rspMsi       <= 1'b0;
        rspFault     <= 1'b1;
        faultCode    <= strb.code;
        faultQual    <= strb.qual;
        faultAddr    <= curAddr;
        errorState   <= 1'b1;
        storeBlocked <= 1'b1;
      end else if (strb.finPage) begin
        rspAddr   <= memRspData & ~PAGE_MASK;
        rspMask   <= PAGE_MASK;
        rspPerm   <= memRspData[PTE_INVALID_BIT] ? PERM_NONE : PERM_RW;
        rspMsi    <= 1'b0;
        rspFault  <= 1'b0;
        faultCode <= FLT_NONE;
        faultQual <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_xlat_walker.sv
module dma_xlat_walker
  import xlat_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int RGN_W      = 11,
  parameter int SEG_W      = 11,
  parameter int PG_W       = 8,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] tblOrigin,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] rspMask,
  output logic [1:0]        rspPerm,
  output logic              rspMsi,
  output logic              rspFault,
  output logic [1:0]        faultCode,
  output logic              faultQual,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              errorState,
  output logic              storeBlocked
);

  strobes_t strb;
  status_t  stat;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .stat       (stat),
    .strb       (strb),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memRdValid (memRdValid)
  );

  xlat_dpath #(
    .ADDR_W    (ADDR_W),
    .RGN_W     (RGN_W),
    .SEG_W     (SEG_W),
    .PG_W      (PG_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .MSI_ADDR  (MSI_ADDR)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .tblOrigin   (tblOrigin),
    .winBase     (winBase),
    .winLimit    (winLimit),
    .memRspData  (memRspData),
    .stat        (stat),
    .memRdAddr   (memRdAddr),
    .rspAddr     (rspAddr),
    .rspMask     (rspMask),
    .rspPerm     (rspPerm),
    .rspMsi      (rspMsi),
    .rspFault    (rspFault),
    .faultCode   (faultCode),
    .faultQual   (faultQual),
    .faultAddr   (faultAddr),
    .errorState  (errorState),
    .storeBlocked(storeBlocked)
  );

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] winBase,
  input logic [ADDR_W-1:0] winLimit,
  input logic              memRdValid,
  input logic              memRspValid,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [ADDR_W-1:0] rspMask,
  input logic [1:0]        rspPerm,
  input logic              rspMsi,
  input logic              rspFault,
  input logic [1:0]        faultCode,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              errorState,
  input logic              storeBlocked
);

  localparam logic [ADDR_W-1:0] OFFS_MASK = ~({ADDR_W{1'b1}} << PAGE_SHIFT);

  logic              outQ;
  logic [ADDR_W-1:0] accAddr, accBase, accLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ     <= 1'b0;
      accAddr  <= '0;
      accBase  <= '0;
      accLimit <= '0;
    end else begin
      if (memRdValid) outQ <= 1'b1;
      else if (memRspValid) outQ <= 1'b0;
      if (reqValid && reqReady) begin
        accAddr  <= reqAddr;
        accBase  <= winBase;
        accLimit <= winLimit;
      end
    end
  end

  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !outQ);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid || rspValid) |-> !reqReady);

  // R1
  msi_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMsi) |-> (accAddr == MSI_ADDR && rspAddr == accAddr &&
                              rspPerm == 2'b11 && rspMask == OFFS_MASK && !rspFault));

  // R3
  range_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && faultCode == 2'd2) |->
      (accAddr < accBase || accAddr > accLimit));

  // R7
  ok_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspMask == OFFS_MASK);

  // R8
  fault_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (errorState && storeBlocked && faultAddr == accAddr));

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errorState && storeBlocked) |=> (errorState && storeBlocked));

endmodule

bind dma_xlat_walker xlat_walker_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_SHIFT(PAGE_SHIFT),
  .MSI_ADDR  (MSI_ADDR)
) u_chk (.*);

// File: tb/dma_xlat_walker_bench.sv
module dma_xlat_walker_bench;

  localparam logic [63:0] MSI = 64'h0000_0000_FE00_0000;
  localparam logic [63:0] ORG = 64'h0000_0000_0001_0005;
  localparam logic [63:0] WB  = 64'h1000;
  localparam logic [63:0] WL  = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0, tblOrigin = '0, winBase = '0, winLimit = '0;
  logic        memRspValid;
  logic [63:0] memRspData;
  logic        reqReady, memRdValid, rspValid, rspMsi, rspFault, faultQual;
  logic        errorState, storeBlocked;
  logic [63:0] memRdAddr, rspAddr, rspMask, faultAddr;
  logic [1:0]  rspPerm, faultCode;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] expReads [$];

  always #5 clk = ~clk;

  dma_xlat_walker u_dma_xlat_walker (.*);

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: result of one request, and the reads it must make
  typedef struct {
    bit          fault;
    logic [1:0]  code;
    bit          qual;
    bit          msi;
    logic [63:0] addr;
    logic [1:0]  perm;
    logic [63:0] mask;
  } res_t;

  task automatic model(input logic [63:0] a, o, b, l, output res_t r);
    logic [63:0] base, e;
    r = '{fault: 0, code: 0, qual: 0, msi: 0, addr: 0, perm: 0, mask: 64'hFFF};
    expReads.delete();
    if (a == MSI) begin
      r.msi = 1; r.addr = a; r.perm = 2'b11;
      return;
    end
    r.mask = '1;
    if (o == 0) begin r.fault = 1; r.code = 1; return; end
    if (a < b || a > l) begin r.fault = 1; r.code = 2; return; end
    base = o & ~64'hF;
    expReads.push_back(base + ((a >> 31) & 64'h7FF) * 8);
    e = rd(expReads[$]);
    if (e[3:2] != 2'b11) begin r.fault = 1; r.code = 3; r.qual = 1; return; end
    base = e & ~64'h3FFF;
    expReads.push_back(base + ((a >> 20) & 64'h7FF) * 8);
    e = rd(expReads[$]);
    if (e[3:2] != 2'b10) begin r.fault = 1; r.code = 3; r.qual = 1; return; end
    base = e & ~64'h7FF;
    expReads.push_back(base + ((a >> 12) & 64'hFF) * 8);
    e = rd(expReads[$]);
    if (e == 0) begin r.fault = 1; r.code = 3; r.qual = 1; return; end
    r.addr = e & ~64'hFFF;
    r.perm = e[10] ? 2'b00 : 2'b11;
    r.mask = 64'hFFF;
  endtask

  // table memory: two-cycle read latency, each read checked against the model
  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rstN && memRdValid) begin
        logic [63:0] a;
        a = memRdAddr;
        if (expReads.size() == 0) chk(0, "R4 unexpected table read", a, 0);
        else begin
          logic [63:0] ea;
          ea = expReads.pop_front();
          chk(a == ea, "R4 table read address", a, ea);
        end
        repeat (2) @(negedge clk);
        memRspData  = rd(a);
        memRspValid = 1'b1;
      end
    end
  end

  task automatic run(input logic [63:0] a, o, b, l, input bit poke, input string tag);
    res_t r;
    int   cyc;
    bit   busyOk;
    bit   early;
    model(a, o, b, l, r);
    early = (expReads.size() == 0);
    @(negedge clk);
    reqAddr = a; tblOrigin = o; winBase = b; winLimit = l; reqValid = 1'b1;
    chk(reqReady == 1'b1, {tag, " R9 ready when idle"}, reqReady, 1);
    @(posedge clk);
    @(negedge clk);
    if (poke) reqAddr = MSI; else reqValid = 1'b0;
    cyc = 1; busyOk = 1;
    while (!rspValid && cyc < 200) begin
      if (reqReady) busyOk = 0;
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    chk(rspValid, {tag, " response seen"}, rspValid, 1);
    chk(busyOk && !reqReady, {tag, " R9 not ready while busy"}, reqReady, 0);
    if (early) chk(cyc == 1, {tag, " R1 R2 R3 one-cycle latency"}, cyc, 1);
    chk(rspFault == r.fault, {tag, " R8 fault flag"}, rspFault, r.fault);
    chk(rspMsi == r.msi, {tag, " R1 msi flag"}, rspMsi, r.msi);
    chk(rspAddr == r.addr, {tag, " R7 address"}, rspAddr, r.addr);
    chk(rspPerm == r.perm, {tag, " R7 permission"}, rspPerm, r.perm);
    chk(rspMask == r.mask, {tag, " R7 R8 mask"}, rspMask, r.mask);
    if (r.fault) begin
      chk(faultCode == r.code, {tag, " R2 R3 R5 R6 fault code"}, faultCode, r.code);
      chk(faultQual == r.qual, {tag, " R6 qualifier"}, faultQual, r.qual);
      chk(faultAddr == a, {tag, " R8 fault address"}, faultAddr, a);
      chk(errorState && storeBlocked, {tag, " R8 flags set"}, {errorState, storeBlocked}, 2'b11);
    end
    chk(expReads.size() == 0, {tag, " R4 R5 all reads done"}, expReads.size(), 0);
    for (int i = 0; i < (poke ? 4 : 1); i++) begin
      @(negedge clk);
      chk(!rspValid && !memRdValid && reqReady, {tag, " R9 idle after response"},
          {rspValid, memRdValid, reqReady}, 3'b001);
    end
  endtask

  initial begin
    // tables: region at 0x10000, segment at 0x20000, page at 0x30000
    mem[64'h10000 + 1 * 8]     = 64'h20000 | 64'hC;
    mem[64'h10000 + 2 * 8]     = 64'h24000 | 64'h8;
    mem[64'h20000 + 2 * 8]     = 64'h30000 | 64'h8;
    mem[64'h20000 + 5 * 8]     = 64'h30800 | 64'h4;
    mem[64'h20000 + 64'h7FF*8] = 64'h30000 | 64'h8;
    mem[64'h30000 + 3 * 8]     = 64'h0000_00AB_CDE0_0001;
    mem[64'h30000 + 4 * 8]     = 64'h0000_0000_1234_5400;
    mem[64'h30000 + 64'hFF*8]  = 64'h0000_0000_7777_7000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !memRdValid && !errorState && !storeBlocked,
        "R10 reset state", {reqReady, rspValid, memRdValid, errorState, storeBlocked}, 5'b10000);

    run(64'h8020_3123, ORG, WB, WL, 0, "R4 R7 valid page");
    run(64'h8020_4000, ORG, WB, WL, 0, "R7 invalid-flag page");
    run(WL,            ORG, WB, WL, 1, "R3 R9 at limit with held request");
    run(MSI,           0,   WB, WL, 0, "R1 bypass beats no origin");
    chk(!errorState && !storeBlocked, "R8 flags clear before any fault",
        {errorState, storeBlocked}, 0);
    run(64'h8020_4000, 0,   WB, WL, 0, "R2 no origin");
    run(64'h800,       ORG, WB, WL, 0, "R3 below base");
    run(64'h1_0000_0000, ORG, WB, WL, 0, "R3 above limit");
    run(WB,            ORG, WB, WL, 0, "R3 R5 at base, unmapped region");
    run(64'h1_0000_0000, ORG, WB, 64'h1_FFFF_FFFF, 0, "R5 bad region type");
    run(64'h8050_0000, ORG, WB, WL, 0, "R5 bad segment type");
    run(64'h8020_9000, ORG, WB, WL, 0, "R6 zero page entry");
    run(64'h8020_3FFF, ORG, WB, WL, 0, "R7 after faults");
    @(negedge clk);
    chk(errorState && storeBlocked, "R8 flags sticky", {errorState, storeBlocked}, 2'b11);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule